// File: doc/BRIEF.md
# Receive Frame Record Writer

This block takes one received Ethernet frame at a time, announced by its length on a small handshake and then streamed in one byte per cycle. It decides at the moment of acceptance whether the frame can be stored. A frame that can be stored claims a buffer page from an external allocator. The block then writes a fixed-layout record into that page, one byte per cycle. The record holds a status word, the record byte count, the even part of the payload, zero padding for short frames, an optional frame check sequence and a two-byte trailer that marks odd length.

When the last record byte has been written, the page number goes onto the receive queue and the receive interrupt is set in the same cycle. A frame that cannot be stored is still taken from the stream and thrown away, so the byte stream never falls out of step. Software reads the record back later, and the offset of every field inside the page is fixed by the layout below.

Top module: `rx_record_writer`

## Requirements
- R1: A frame is dropped when rx_enable is low, when soft_reset is high, when page_avail is low, or when its byte count (R2) is above 2048. These are sampled in the accept cycle. A dropped frame gives no page_take, no buffer write, no q_push and no irq_set, and its frame_len bytes are still consumed through byte_ready.
- R2: The byte count is 64 for a frame shorter than 64 bytes and otherwise the length with bit 0 cleared. Add 6 to that, and add 4 more when strip_crc is low. It is stored at page address 2 (low byte) and address 3 (high byte).
- R3: Page address 0 holds the low byte and address 1 the high byte of a status word. In that word bit 12 is set for an odd frame length, bit 11 is set for a length above 1518, and all other bits are zero.
- R4: The frame bytes at index 0 up to the largest even index below the length are stored in order starting at address 4.
- R5: For a frame shorter than 64 bytes with an odd length, the last frame byte is stored right after the even part. In every frame shorter than 64 bytes, zero bytes then fill the record up to and including address 67.
- R6: When strip_crc is low, a CRC-32 follows the data area, least significant byte first. It uses the reflected polynomial 0xEDB88320 with an all-ones start value and an inverted result. It covers all frame bytes, including an odd last byte, and then the zero fill for frames shorter than 64 bytes.
- R7: The last two record bytes are the last frame byte followed by 0x60 for an odd frame of 64 bytes or more. In every other case they are 0x00 followed by 0x40.
- R8: After the last record write, q_push is high for exactly one cycle with q_page equal to the granted page, and irq_set is high in that same cycle.
- R9: An accepted frame writes at most one byte per cycle to consecutive addresses starting at 0, all in the granted page. The number of writes equals the byte count of R2.
- R10: page_take is high only in a cycle where frame_valid and frame_ready are both high. frame_ready stays low from an accepted frame until its q_push has passed.
- R11: During and right after reset, frame_ready is high and buf_we and q_push are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receive enable, sampled at frame accept |
| soft_reset | input | 1 | Soft reset in progress; frames are dropped |
| strip_crc | input | 1 | High: no CRC bytes in the record |
| frame_valid | input | 1 | A frame length is offered |
| frame_len | input | LEN_W | Frame length in bytes |
| frame_ready | output | 1 | Block is idle and takes a frame |
| byte_valid | input | 1 | byte_data carries the next frame byte |
| byte_data | input | 8 | Frame byte |
| byte_ready | output | 1 | Frame byte is consumed this cycle when valid |
| page_avail | input | 1 | Allocator has a free page |
| page_id | input | PG_W | Number of the free page |
| page_take | output | 1 | Claim of page_id, one cycle |
| buf_we | output | 1 | Buffer write strobe |
| buf_page | output | PG_W | Page of the write |
| buf_addr | output | ADDR_W | Byte address inside the page |
| buf_wdata | output | 8 | Write data |
| q_push | output | 1 | Append q_page to the receive queue |
| q_page | output | PG_W | Page of the finished record |
| irq_set | output | 1 | Set the receive interrupt |

## Verification
Lengths are swept around 64 in both parities, so the even-part/odd-byte/zero-fill split and the short-frame trailer rule are separated from the long odd trailer. Lengths near 1518 toggle the oversize status flag on their own. Lengths near the 2048-byte count limit are run with and without CRC, which shows that the limit applies to the computed count and not to the raw length. Each drop cause is applied alone to show that nothing is written and the stream still drains, and the page number rotates between frames so that writes landing in a stale page are caught.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_PAYLOAD, S_PAD, S_CRC, S_TRAILER, S_DONE, S_DISCARD
  } rxw_state_e;

  // Record byte count: data area plus header, trailer and optional FCS.
  function automatic logic [15:0] rec_bytes(input logic [15:0] len,
                                            input logic [15:0] min_len,
                                            input logic        keep_fcs);
    logic [15:0] body;
    body = (len < min_len) ? min_len : (len & 16'hFFFE);
    return body + 16'd6 + (keep_fcs ? 16'd4 : 16'd0);
  endfunction

  // Status word: odd-length flag and oversize flag.
  function automatic logic [15:0] rec_status(input logic [15:0] len,
                                             input logic [15:0] max_len);
    logic [15:0] s;
    s     = '0;
    s[12] = len[0];
    s[11] = (len > max_len);
    return s;
  endfunction

  // One byte step of the reflected CRC-32.
  function automatic logic [31:0] crc_step(input logic [31:0] c,
                                           input logic [7:0]  b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rxw_admit.sv
module rxw_admit
  import rxw_pkg::*;
#(
  parameter int LEN_W      = 11,
  parameter int PAGE_BYTES = 2048,
  parameter int MIN_FRAME  = 64,
  parameter int MAX_FRAME  = 1518
) (
  input  logic [LEN_W-1:0] frame_len,
  input  logic             rx_enable,
  input  logic             soft_reset,
  input  logic             keep_fcs,
  input  logic             page_avail,
  output logic             drop,
  output logic [15:0]      count,
  output logic [15:0]      status,
  output logic             is_short
);
  localparam logic [15:0] MINL  = 16'(MIN_FRAME);
  localparam logic [15:0] MAXL  = 16'(MAX_FRAME);
  localparam logic [15:0] LIMIT = 16'(PAGE_BYTES);

  logic [15:0] len16;
  assign len16    = 16'(frame_len);
  assign count    = rec_bytes(len16, MINL, keep_fcs);
  assign status   = rec_status(len16, MAXL);
  assign is_short = (len16 < MINL);
  assign drop     = !rx_enable || soft_reset || !page_avail || (count > LIMIT);
endmodule

// File: rtl/rxw_crc.sv
module rxw_crc
  import rxw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] fcs
);
  logic [31:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '1;
    else if (clear) acc_q <= '1;
    else if (en)    acc_q <= crc_step(acc_q, din);
  end

  assign fcs = ~acc_q;
endmodule

// File: rtl/rxw_seq.sv
module rxw_seq
  import rxw_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int PG_W      = 2,
  parameter int ADDR_W    = 11,
  parameter int MIN_FRAME = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_valid,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              drop,
  input  logic [15:0]       count,
  input  logic [15:0]       status,
  input  logic              is_short,
  input  logic              keep_fcs,
  input  logic [PG_W-1:0]   page_id,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic [31:0]       fcs,
  output logic              frame_ready,
  output logic              byte_ready,
  output logic              page_take,
  output logic              buf_we,
  output logic [PG_W-1:0]   buf_page,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_wdata,
  output logic              q_push,
  output logic [PG_W-1:0]   q_page,
  output logic              irq_set,
  output logic              crc_clear,
  output logic              crc_en,
  output logic [7:0]        crc_din,
  output logic [15:0]       rec_len
);
  localparam logic [ADDR_W-1:0] PAD_LAST = ADDR_W'(4 + MIN_FRAME - 1);

  rxw_state_e        state_q, state_d;
  logic [LEN_W-1:0]  len_q, pos_q;
  logic [PG_W-1:0]   page_q;
  logic              keep_q, short_q, odd_q;
  logic [15:0]       count_q, status_q;
  logic [7:0]        held_q;
  logic [ADDR_W-1:0] wa_q;
  logic [1:0]        idx_q;

  logic              last_byte;
  logic              long_odd;
  logic [ADDR_W-1:0] odd_slot;
  logic              at_odd_slot;

  assign last_byte   = (pos_q == (len_q - LEN_W'(1)));
  assign long_odd    = odd_q && !short_q;
  assign odd_slot    = ADDR_W'(4) + ADDR_W'({len_q[LEN_W-1:1], 1'b0});
  assign at_odd_slot = odd_q && (wa_q == odd_slot);

  always_comb begin
    state_d     = state_q;
    frame_ready = 1'b0;
    byte_ready  = 1'b0;
    page_take   = 1'b0;
    buf_we      = 1'b0;
    buf_wdata   = 8'h00;
    q_push      = 1'b0;
    crc_clear   = 1'b0;
    crc_en      = 1'b0;
    crc_din     = byte_data;
    unique case (state_q)
      S_IDLE: begin
        frame_ready = 1'b1;
        if (frame_valid) begin
          if (drop) begin
            state_d = (frame_len == '0) ? S_IDLE : S_DISCARD;
          end else begin
            page_take = 1'b1;
            crc_clear = 1'b1;
            state_d   = S_HDR;
          end
        end
      end
      S_HDR: begin
        buf_we = 1'b1;
        unique case (idx_q)
          2'd0:    buf_wdata = status_q[7:0];
          2'd1:    buf_wdata = status_q[15:8];
          2'd2:    buf_wdata = count_q[7:0];
          default: buf_wdata = count_q[15:8];
        endcase
        if (idx_q == 2'd3) state_d = (len_q == '0) ? S_PAD : S_PAYLOAD;
      end
      S_PAYLOAD: begin
        byte_ready = 1'b1;
        if (byte_valid) begin
          crc_en    = 1'b1;
          buf_we    = !(last_byte && odd_q);
          buf_wdata = byte_data;
          if (last_byte) begin
            if (short_q)     state_d = S_PAD;
            else if (keep_q) state_d = S_CRC;
            else             state_d = S_TRAILER;
          end
        end
      end
      S_PAD: begin
        buf_we    = 1'b1;
        buf_wdata = at_odd_slot ? held_q : 8'h00;
        crc_en    = !at_odd_slot;
        crc_din   = 8'h00;
        if (wa_q == PAD_LAST) state_d = keep_q ? S_CRC : S_TRAILER;
      end
      S_CRC: begin
        buf_we    = 1'b1;
        buf_wdata = fcs[8*idx_q +: 8];
        if (idx_q == 2'd3) state_d = S_TRAILER;
      end
      S_TRAILER: begin
        buf_we = 1'b1;
        if (idx_q == 2'd0) buf_wdata = long_odd ? held_q : 8'h00;
        else               buf_wdata = long_odd ? 8'h60 : 8'h40;
        if (idx_q == 2'd1) state_d = S_DONE;
      end
      S_DONE: begin
        q_push  = 1'b1;
        state_d = S_IDLE;
      end
      S_DISCARD: begin
        byte_ready = 1'b1;
        if (byte_valid && last_byte) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      len_q    <= '0;
      pos_q    <= '0;
      page_q   <= '0;
      keep_q   <= 1'b0;
      short_q  <= 1'b0;
      odd_q    <= 1'b0;
      count_q  <= '0;
      status_q <= '0;
      held_q   <= '0;
      wa_q     <= '0;
      idx_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) idx_q <= '0;
      else                    idx_q <= idx_q + 2'd1;
      if (state_q == S_IDLE && frame_valid) begin
        len_q <= frame_len;
        pos_q <= '0;
      end
      if (page_take) begin
        page_q   <= page_id;
        keep_q   <= keep_fcs;
        short_q  <= is_short;
        odd_q    <= frame_len[0];
        count_q  <= count;
        status_q <= status;
        wa_q     <= '0;
      end else if (buf_we) begin
        wa_q <= wa_q + ADDR_W'(1);
      end
      if (byte_ready && byte_valid) begin
        pos_q <= pos_q + LEN_W'(1);
        if (state_q == S_PAYLOAD && last_byte) held_q <= byte_data;
      end
    end
  end

  assign buf_page = page_q;
  assign buf_addr = wa_q;
  assign q_page   = page_q;
  assign irq_set  = q_push;
  assign rec_len  = count_q;
endmodule

// File: rtl/rx_record_writer.sv
module rx_record_writer #(
  parameter int  LEN_W      = 11,
  parameter int  PAGES      = 4,
  parameter int  PAGE_BYTES = 2048,
  parameter int  MIN_FRAME  = 64,
  parameter int  MAX_FRAME  = 1518,
  localparam int PG_W       = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int ADDR_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              soft_reset,
  input  logic              strip_crc,
  input  logic              frame_valid,
  input  logic [LEN_W-1:0]  frame_len,
  output logic              frame_ready,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic              byte_ready,
  input  logic              page_avail,
  input  logic [PG_W-1:0]   page_id,
  output logic              page_take,
  output logic              buf_we,
  output logic [PG_W-1:0]   buf_page,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_wdata,
  output logic              q_push,
  output logic [PG_W-1:0]   q_page,
  output logic              irq_set
);
  logic        drop_w, short_w;
  logic [15:0] count_w, status_w;
  logic        crc_clear, crc_en;
  logic [7:0]  crc_din;
  logic [31:0] fcs_w;
  logic [15:0] rec_len;
  logic        keep_fcs;

  assign keep_fcs = !strip_crc;

  rxw_admit #(
    .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
    .MIN_FRAME(MIN_FRAME), .MAX_FRAME(MAX_FRAME)
  ) u_admit (
    .frame_len (frame_len),
    .rx_enable (rx_enable),
    .soft_reset(soft_reset),
    .keep_fcs  (keep_fcs),
    .page_avail(page_avail),
    .drop      (drop_w),
    .count     (count_w),
    .status    (status_w),
    .is_short  (short_w)
  );

  rxw_crc u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(crc_clear),
    .en   (crc_en),
    .din  (crc_din),
    .fcs  (fcs_w)
  );

  rxw_seq #(
    .LEN_W(LEN_W), .PG_W(PG_W), .ADDR_W(ADDR_W), .MIN_FRAME(MIN_FRAME)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_valid(frame_valid),
    .frame_len  (frame_len),
    .drop       (drop_w),
    .count      (count_w),
    .status     (status_w),
    .is_short   (short_w),
    .keep_fcs   (keep_fcs),
    .page_id    (page_id),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .fcs        (fcs_w),
    .frame_ready(frame_ready),
    .byte_ready (byte_ready),
    .page_take  (page_take),
    .buf_we     (buf_we),
    .buf_page   (buf_page),
    .buf_addr   (buf_addr),
    .buf_wdata  (buf_wdata),
    .q_push     (q_push),
    .q_page     (q_page),
    .irq_set    (irq_set),
    .crc_clear  (crc_clear),
    .crc_en     (crc_en),
    .crc_din    (crc_din),
    .rec_len    (rec_len)
  );
endmodule

// File: rtl/rx_record_writer_chk.sv
module rx_record_writer_chk #(
  parameter int PG_W   = 2,
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_valid,
  input logic              frame_ready,
  input logic              page_take,
  input logic [PG_W-1:0]   page_id,
  input logic              buf_we,
  input logic [PG_W-1:0]   buf_page,
  input logic [ADDR_W-1:0] buf_addr,
  input logic              q_push,
  input logic [PG_W-1:0]   q_page,
  input logic              irq_set,
  input logic [15:0]       rec_len
);
  logic [15:0]     exp_addr;
  logic [PG_W-1:0] pg;
  logic            busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_addr <= '0;
      pg       <= '0;
      busy     <= 1'b0;
    end else if (page_take) begin
      exp_addr <= '0;
      pg       <= page_id;
      busy     <= 1'b1;
    end else begin
      if (buf_we) exp_addr <= exp_addr + 16'd1;
      if (q_push) busy <= 1'b0;
    end
  end

  assert_no_write_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !buf_we);
  assert_addr_seq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (16'(buf_addr) == exp_addr));
  assert_page_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (buf_page == pg));
  assert_len_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> (exp_addr == rec_len));
  assert_push_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> (irq_set && !buf_we && busy && q_page == pg));
  assert_push_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |=> !q_push);
  assert_take_hs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    page_take |-> (frame_valid && frame_ready));
  assert_busy_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    page_take |=> !frame_ready);
endmodule

bind rx_record_writer rx_record_writer_chk #(.PG_W(PG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_valid(frame_valid),
  .frame_ready(frame_ready),
  .page_take  (page_take),
  .page_id    (page_id),
  .buf_we     (buf_we),
  .buf_page   (buf_page),
  .buf_addr   (buf_addr),
  .q_push     (q_push),
  .q_page     (q_page),
  .irq_set    (irq_set),
  .rec_len    (rec_len)
);

// File: tb/rx_record_writer_bench.sv
`timescale 1ns/1ps
module rx_record_writer_bench;
  localparam int LEN_W = 11;
  localparam int PAGES = 4;
  localparam int PB    = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_enable = 1'b0, soft_reset = 1'b0, strip_crc = 1'b0;
  logic        frame_valid = 1'b0;
  logic [10:0] frame_len = '0;
  logic        frame_ready;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        byte_ready;
  logic        page_avail = 1'b0;
  logic [1:0]  page_id = '0;
  logic        page_take, buf_we, q_push, irq_set;
  logic [1:0]  buf_page, q_page;
  logic [10:0] buf_addr;
  logic [7:0]  buf_wdata;

  always #4 clk = ~clk;

  rx_record_writer u_rx_record_writer (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .soft_reset(soft_reset),
    .strip_crc(strip_crc), .frame_valid(frame_valid), .frame_len(frame_len),
    .frame_ready(frame_ready), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .page_avail(page_avail), .page_id(page_id),
    .page_take(page_take), .buf_we(buf_we), .buf_page(buf_page),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .q_push(q_push),
    .q_page(q_page), .irq_set(irq_set)
  );

  int checks = 0, fails = 0;
  int wr_cnt, push_cnt, irq_cnt, take_cnt, page_err, push_page, cur_page = 0;
  logic [7:0]  bmem [0:PAGES*PB-1];
  logic [7:0]  exp_rec [0:PB-1];
  logic [31:0] ctab [0:255];
  int exp_n, exp_body;
  bit exp_short;

  always @(posedge clk) begin
    if (rst_n) begin
      if (buf_we) begin
        bmem[int'(buf_page)*PB + int'(buf_addr)] = buf_wdata;
        wr_cnt++;
        if (int'(buf_page) != cur_page) page_err++;
      end
      if (q_push) begin push_cnt++; push_page = int'(q_page); end
      if (irq_set) irq_cnt++;
      if (page_take) take_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int len, input int i);
    return 8'((i * 29 + len * 3 + 17) ^ (i >> 3));
  endfunction

  function automatic logic [31:0] crc_add(input logic [31:0] c, input logic [7:0] b);
    return ctab[(c ^ 32'(b)) & 32'hFF] ^ (c >> 8);
  endfunction

  // Record model built from the requirements.
  task automatic build(input int len, input bit keep);
    logic [31:0] c;
    int p, st;
    exp_short = (len < 64);
    exp_body  = exp_short ? 64 : (len & ~1);
    exp_n     = exp_body + 6 + (keep ? 4 : 0);
    st = ((len % 2) << 12) | ((len > 1518) ? (1 << 11) : 0);
    if (exp_n > PB) return;
    exp_rec[0] = 8'(st); exp_rec[1] = 8'(st >> 8);
    exp_rec[2] = 8'(exp_n); exp_rec[3] = 8'(exp_n >> 8);
    p = 4;
    for (int i = 0; i < (len & ~1); i++) begin exp_rec[p] = pat(len, i); p++; end
    if (exp_short) begin
      if (len % 2 == 1) begin exp_rec[p] = pat(len, len - 1); p++; end
      while (p < 68) begin exp_rec[p] = 8'h00; p++; end
    end
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < len; i++) c = crc_add(c, pat(len, i));
    if (exp_short) for (int i = len; i < 64; i++) c = crc_add(c, 8'h00);
    c = ~c;
    if (keep) for (int k = 0; k < 4; k++) begin exp_rec[p] = 8'(c >> (8 * k)); p++; end
    if (len % 2 == 1 && !exp_short) begin
      exp_rec[p] = pat(len, len - 1); exp_rec[p + 1] = 8'h60;
    end else begin
      exp_rec[p] = 8'h00; exp_rec[p + 1] = 8'h40;
    end
  endtask

  task automatic cmp(input string req, input string what, input int from, input int upto);
    int bad_a;
    bad_a = -1;
    for (int a = from; a < upto; a++)
      if (bad_a < 0 && bmem[cur_page * PB + a] !== exp_rec[a]) bad_a = a;
    if (bad_a < 0) chk(1'b1, req, what, 0, 0);
    else chk(1'b0, req, $sformatf("%s addr %0d", what, bad_a),
             bmem[cur_page * PB + bad_a], exp_rec[bad_a]);
  endtask

  task automatic run_frame(input int len, input bit keep, input bit en,
                           input bit srst, input bit avail);
    bit ok;
    int i;
    build(len, keep);
    ok = en && !srst && avail && (exp_n <= PB);
    @(negedge clk);
    strip_crc = !keep; rx_enable = en; soft_reset = srst;
    page_avail = avail; page_id = 2'(cur_page);
    for (int a = 0; a < PB; a++) bmem[cur_page * PB + a] = 8'h5A;
    wr_cnt = 0; push_cnt = 0; irq_cnt = 0; take_cnt = 0; page_err = 0; push_page = -1;
    frame_valid = 1'b1; frame_len = 11'(len);
    @(negedge clk);
    frame_valid = 1'b0;
    if (ok) chk(frame_ready == 1'b0, "R10", "ready while writing", frame_ready, 0);
    i = 0;
    while (i < len) begin
      @(negedge clk);
      byte_valid = 1'b1; byte_data = pat(len, i);
      if (byte_ready) i++;
    end
    @(negedge clk);
    byte_valid = 1'b0;
    for (int w = 0; w < 300 && push_cnt == 0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
    if (ok) begin
      chk(take_cnt == 1, "R10", $sformatf("page claims len %0d", len), take_cnt, 1);
      chk(wr_cnt == exp_n, "R9", $sformatf("write count len %0d", len), wr_cnt, exp_n);
      chk(page_err == 0, "R9", "writes outside granted page", page_err, 0);
      chk(push_cnt == 1 && irq_cnt == 1, "R8", "push and irq pulses",
          push_cnt * 10 + irq_cnt, 11);
      chk(push_page == cur_page, "R8", "queued page", push_page, cur_page);
      cmp("R3", "status word", 0, 2);
      cmp("R2", "byte count", 2, 4);
      cmp("R4", "even payload", 4, 4 + (len & ~1));
      if (exp_short) cmp("R5", "short fill", 4 + (len & ~1), 68);
      if (keep) cmp("R6", "crc bytes", 4 + exp_body, 8 + exp_body);
      cmp("R7", "trailer", exp_n - 2, exp_n);
    end else begin
      chk(take_cnt == 0 && wr_cnt == 0 && push_cnt == 0 && irq_cnt == 0, "R1",
          $sformatf("drop len %0d activity", len),
          take_cnt + wr_cnt + push_cnt + irq_cnt, 0);
    end
    chk(frame_ready == 1'b1, "R10", "ready after frame", frame_ready, 1);
    cur_page = (cur_page + 1) % PAGES;
  endtask

  initial begin
    int sweep [14] = '{0, 1, 2, 3, 62, 63, 64, 65, 66, 127, 1517, 1518, 1519, 1520};
    for (int n = 0; n < 256; n++) begin
      logic [31:0] v;
      v = 32'(n);
      for (int k = 0; k < 8; k++) v = v[0] ? ((v >> 1) ^ 32'hEDB88320) : (v >> 1);
      ctab[n] = v;
    end
    repeat (3) @(negedge clk);
    chk(frame_ready == 1'b1 && buf_we == 1'b0 && q_push == 1'b0, "R11",
        "state in reset", {frame_ready, buf_we, q_push}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frame_ready == 1'b1 && buf_we == 1'b0 && q_push == 1'b0, "R11",
        "state after reset", {frame_ready, buf_we, q_push}, 3'b100);
    foreach (sweep[s]) begin
      run_frame(sweep[s], 1'b1, 1'b1, 1'b0, 1'b1);
      run_frame(sweep[s], 1'b0, 1'b1, 1'b0, 1'b1);
    end
    // byte count limit boundary, R1 and R2
    for (int l = 2037; l <= 2041; l++) run_frame(l, 1'b1, 1'b1, 1'b0, 1'b1);
    for (int l = 2041; l <= 2044; l++) run_frame(l, 1'b0, 1'b1, 1'b0, 1'b1);
    run_frame(2047, 1'b0, 1'b1, 1'b0, 1'b1);
    // each drop cause alone, R1
    run_frame(70, 1'b1, 1'b0, 1'b0, 1'b1);
    run_frame(70, 1'b1, 1'b1, 1'b1, 1'b1);
    run_frame(71, 1'b0, 1'b1, 1'b0, 1'b0);
    run_frame(0, 1'b1, 1'b0, 1'b0, 1'b1);
    run_frame(65, 1'b1, 1'b1, 1'b0, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule